// File: doc/BRIEF.md
# Two-Wire Debug Link Target Engine

This block is the target end of a two-wire serial debug link. On every rising edge of the host-supplied clock it samples the shared data line. It recognises an 8-bit request header, answers with a 3-bit acknowledge, and moves a 32-bit payload with a parity bit either from the host or to the host, as the header selects. It controls the output enable of the shared line, so that the target drives the line only during the acknowledge and the read data. One turnaround cycle separates each change of line ownership.

Toward the debug port the engine presents a one-cycle request strobe. The strobe carries the port-select bit (access port or debug port), the direction, the 2-bit register address and the write data. The debug port answers with read data, a ready level and an error level. A write strobe goes out only when the write data parity is correct. Access-port reads are posted: the data the host receives is the result of the previous access-port read. A wrong write parity sets a sticky error. While that error or the debug port's error is set, every request answers FAULT, except debug-port register 0. The host uses that register to read identity and to clear the error.

Top module: `swd_target_engine`

## Requirements
- R1: A header is accepted only when bit 0 (start) is 1, bit 6 (stop) is 0, bit 7 (park) is 1, and bit 5 gives even parity over bit 1 (port select, 1 = access port), bit 2 (direction, 1 = read) and bits 3..4 (address, bit 3 is the LSB). Header bits arrive in cycles 1 to 8. A rejected header gets no drive on the line and no request strobe.
- R2: After an accepted header, cycle 9 is a turnaround with the line undriven. In cycles 10 to 12 the target drives the acknowledge LSB first: OK = 001, WAIT = 010, FAULT = 100.
- R3: The acknowledge uses ready_i and error_i as sampled at the end of cycle 8. The engine answers FAULT when error_i or the sticky write error is set and the request is not debug-port address 0. Otherwise it answers WAIT when ready_i is low, and OK in all other cases.
- R4: After WAIT or FAULT there is no data phase and no request strobe. The line is undriven in cycle 13, and the next start bit may arrive in cycle 14.
- R5: An OK read drives data LSB first in cycles 13 to 44 and even parity in cycle 45. It releases the line in cycle 46, and the next start may arrive in cycle 47.
- R6: An OK read raises the request strobe in cycle 9 with rnw_o = 1. A debug-port read returns the rdata_i value present in that cycle.
- R7: An access-port read returns the data captured by the previous access-port read (0 after reset) and stores the current rdata_i for the next one. Debug-port reads leave the stored value unchanged.
- R8: An OK write leaves the line undriven in cycle 13 and takes data LSB first in cycles 14 to 45 and parity in cycle 46. With correct even parity, it raises the request strobe for exactly one cycle (cycle 47) with rnw_o = 0 and the received data.
- R9: A write whose parity bit is wrong raises no strobe and sets the sticky write error.
- R10: A correct-parity write to debug-port address 0 clears the sticky write error and is strobed like any other write.
- R11: Between packets the line may idle low for any number of cycles. The target does not drive it and raises no strobe.
- R12: After reset the line is undriven and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| swclk_i | input | 1 | Link clock from the host, rising-edge sampled |
| rst_ni | input | 1 | Active-low asynchronous reset |
| swdio_i | input | 1 | Data line as seen by the target |
| swdio_o | output | 1 | Value the target puts on the line |
| swdio_oe_o | output | 1 | Target drives the line when high |
| req_o | output | 1 | One-cycle register access strobe |
| apndp_o | output | 1 | 1 = access port, 0 = debug port |
| rnw_o | output | 1 | 1 = read, 0 = write |
| addr_o | output | 2 | Register address within the bank |
| wdata_o | output | 32 | Write data, valid with a write strobe |
| rdata_i | input | 32 | Read data, sampled in the read strobe cycle |
| ready_i | input | 1 | Debug port can accept a transfer |
| error_i | input | 1 | Debug port sticky error |

## Verification
On every cycle the assertions check several properties. The strobe is always a single cycle, and it never coincides with the target driving the line. A read strobe is always followed by the target taking the line. A write strobe only follows an OK acknowledge. While the line is driven, exactly one acknowledge code is held. The bench scenarios cover the behaviour that depends on packet history and exact bit timing: posted access-port data, the sticky-error fault and its clearing through debug-port address 0, rejected headers, and the 13-, 46-cycle packet lengths with back-to-back starts.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_TRN, ST_ACK, ST_WTRN, ST_WDATA, ST_RDATA, ST_TEND
  } swd_state_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam int unsigned HDR_W = 8;
  localparam int unsigned ACK_W = 3;

  typedef struct packed {
    logic       apndp;
    logic       rnw;
    logic [1:0] addr;
  } swd_req_t;
endpackage

// File: rtl/swd_parity.sv
module swd_parity #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] d_i,
  output logic         par_o
);
  assign par_o = ^d_i;
endmodule

// File: rtl/swd_hdr_dec.sv
module swd_hdr_dec
  import swd_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_i,
  output logic             valid_o,
  output swd_req_t         req_o
);
  logic par_calc;

  assign req_o.apndp = hdr_i[1];
  assign req_o.rnw   = hdr_i[2];
  assign req_o.addr  = hdr_i[4:3];

  swd_parity #(.W(4)) u_par (
    .d_i   (hdr_i[4:1]),
    .par_o (par_calc)
  );

  assign valid_o = hdr_i[0] && !hdr_i[6] && hdr_i[7] && (par_calc == hdr_i[5]);
endmodule

// File: rtl/swd_ack_sel.sv
module swd_ack_sel
  import swd_pkg::*;
(
  input  logic             apndp_i,
  input  logic [1:0]       addr_i,
  input  logic             ready_i,
  input  logic             error_i,
  input  logic             sticky_i,
  output logic [ACK_W-1:0] ack_o
);
  logic bypass;

  // debug-port register 0 stays reachable while faulted
  assign bypass = !apndp_i && (addr_i == 2'b00);

  always_comb begin
    if ((error_i || sticky_i) && !bypass) ack_o = ACK_FAULT;
    else if (!ready_i)                    ack_o = ACK_WAIT;
    else                                  ack_o = ACK_OK;
  end
endmodule

// File: rtl/swd_target_engine.sv
module swd_target_engine
  import swd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          swclk_i,
  input  logic          rst_ni,
  input  logic          swdio_i,
  output logic          swdio_o,
  output logic          swdio_oe_o,
  output logic          req_o,
  output logic          apndp_o,
  output logic          rnw_o,
  output logic [1:0]    addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          ready_i,
  input  logic          error_i
);
  localparam int unsigned CNT_W = $clog2(DW + 2);
  localparam int unsigned IDX_W = $clog2(DW);
  localparam logic [CNT_W-1:0] CNT_DW = CNT_W'(DW);
  localparam logic [CNT_W-1:0] CNT_DW1 = CNT_W'(DW + 1);

  swd_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       hdr_sr_q;
  swd_req_t         cur_q;
  logic [ACK_W-1:0] ack_q;
  logic [DW-1:0]    sr_q;
  logic [DW-1:0]    post_q;
  logic             wr_err_q;
  logic             out_q;
  logic             oe_q;
  logic             req_q;

  logic             hdr_ok;
  swd_req_t         hdr_req;
  logic [ACK_W-1:0] ack_new;
  logic             sr_par;
  logic             is_abort;

  swd_hdr_dec u_dec (
    .hdr_i   ({swdio_i, hdr_sr_q}),
    .valid_o (hdr_ok),
    .req_o   (hdr_req)
  );

  swd_ack_sel u_ack (
    .apndp_i  (hdr_req.apndp),
    .addr_i   (hdr_req.addr),
    .ready_i  (ready_i),
    .error_i  (error_i),
    .sticky_i (wr_err_q),
    .ack_o    (ack_new)
  );

  swd_parity #(.W(DW)) u_dpar (
    .d_i   (sr_q),
    .par_o (sr_par)
  );

  assign is_abort = !cur_q.apndp && (cur_q.addr == 2'b00);

  always_ff @(posedge swclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      hdr_sr_q <= '0;
      cur_q    <= '0;
      ack_q    <= '0;
      sr_q     <= '0;
      post_q   <= '0;
      wr_err_q <= 1'b0;
      out_q    <= 1'b0;
      oe_q     <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          oe_q <= 1'b0;
          if (swdio_i) begin
            hdr_sr_q <= 7'b1000000;
            cnt_q    <= CNT_W'(1);
            state_q  <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (cnt_q == CNT_W'(7)) begin
            if (hdr_ok) begin
              cur_q   <= hdr_req;
              ack_q   <= ack_new;
              state_q <= ST_TRN;
              if (ack_new == ACK_OK && hdr_req.rnw) req_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            hdr_sr_q <= {swdio_i, hdr_sr_q[6:1]};
            cnt_q    <= cnt_q + CNT_W'(1);
          end
        end
        ST_TRN: begin
          if (ack_q == ACK_OK && cur_q.rnw) begin
            // rdata_i is valid while the read strobe is high
            if (cur_q.apndp) begin
              sr_q   <= post_q;
              post_q <= rdata_i;
            end else begin
              sr_q <= rdata_i;
            end
          end
          oe_q    <= 1'b1;
          out_q   <= ack_q[0];
          cnt_q   <= CNT_W'(1);
          state_q <= ST_ACK;
        end
        ST_ACK: begin
          if (cnt_q < CNT_W'(3)) begin
            out_q <= ack_q[cnt_q[1:0]];
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (ack_q == ACK_OK && cur_q.rnw) begin
            out_q   <= sr_q[0];
            cnt_q   <= CNT_W'(1);
            state_q <= ST_RDATA;
          end else if (ack_q == ACK_OK) begin
            oe_q    <= 1'b0;
            state_q <= ST_WTRN;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_TEND;
          end
        end
        ST_RDATA: begin
          if (cnt_q < CNT_DW) begin
            out_q <= sr_q[cnt_q[IDX_W-1:0]];
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (cnt_q == CNT_DW) begin
            out_q <= sr_par;
            cnt_q <= CNT_DW1;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_TEND;
          end
        end
        ST_WTRN: begin
          cnt_q   <= '0;
          state_q <= ST_WDATA;
        end
        ST_WDATA: begin
          if (cnt_q < CNT_DW) begin
            sr_q[cnt_q[IDX_W-1:0]] <= swdio_i;
            cnt_q <= cnt_q + CNT_W'(1);
          end else begin
            if (sr_par == swdio_i) begin
              req_q <= 1'b1;
              if (is_abort) wr_err_q <= 1'b0;
            end else begin
              wr_err_q <= 1'b1;
            end
            state_q <= ST_IDLE;
          end
        end
        ST_TEND: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign swdio_o    = out_q;
  assign swdio_oe_o = oe_q;
  assign req_o      = req_q;
  assign apndp_o    = cur_q.apndp;
  assign rnw_o      = cur_q.rnw;
  assign addr_o     = cur_q.addr;
  assign wdata_o    = sr_q;
endmodule

// File: rtl/swd_target_engine_chk.sv
module swd_target_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       swdio_oe_o,
  input logic       req_o,
  input logic       rnw_o,
  input logic [2:0] ack_q
);
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o); // R8

  AST_REQ_LINE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !swdio_oe_o); // R6

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && rnw_o) |=> swdio_oe_o); // R5

  AST_WRITE_AFTER_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rnw_o) |-> (ack_q == 3'b001)); // R8

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swdio_oe_o |-> ($countones(ack_q) == 1)); // R2

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swdio_oe_o) |=> swdio_oe_o); // R2
endmodule

bind swd_target_engine swd_target_engine_chk u_chk (
  .clk_i      (swclk_i),
  .rst_ni     (rst_ni),
  .swdio_oe_o (swdio_oe_o),
  .req_o      (req_o),
  .rnw_o      (rnw_o),
  .ack_q      (ack_q)
);

// File: tb/swd_target_engine_test.sv
module swd_target_engine_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 32;

  typedef struct packed {
    logic          apndp;
    logic          rnw;
    logic [1:0]    addr;
    logic [DW-1:0] wdata;
  } exp_req_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swdio_i = 1'b0;
  logic swdio_o, swdio_oe;
  logic req, apndp, rnw;
  logic [1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rd_val = '0;
  logic ready = 1'b1;
  logic err = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  exp_req_t exp_q[$];
  logic sticky_m = 1'b0;
  logic [DW-1:0] post_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swd_target_engine #(.DW(DW)) uut (
    .swclk_i    (clk),
    .rst_ni     (rst_n),
    .swdio_i    (swdio_i),
    .swdio_o    (swdio_o),
    .swdio_oe_o (swdio_oe),
    .req_o      (req),
    .apndp_o    (apndp),
    .rnw_o      (rnw),
    .addr_o     (addr),
    .wdata_o    (wdata),
    .rdata_i    (rd_val),
    .ready_i    (ready),
    .error_i    (err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every strobe must match the oldest expected access
  always @(negedge clk) begin
    if (rst_n && req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected strobe", {apndp, rnw, addr}, 0);
      end else begin
        exp_req_t e;
        e = exp_q.pop_front();
        chk({apndp, rnw, addr} == {e.apndp, e.rnw, e.addr}, "R6/R8 strobe fields",
            {apndp, rnw, addr}, {e.apndp, e.rnw, e.addr});
        if (!e.rnw) chk(wdata == e.wdata, "R8 write data", wdata, e.wdata);
      end
    end
  end

  // one link cycle: sample target outputs, then drive the host bit
  task automatic cyc(input logic d, output logic en, output logic v);
    @(negedge clk);
    en = swdio_oe;
    v = swdio_o;
    swdio_i = d;
  endtask

  function automatic logic [2:0] model_ack(input logic ap, input logic [1:0] a);
    if ((err || sticky_m) && !(!ap && a == 2'b00)) return 3'b100;
    if (!ready) return 3'b010;
    return 3'b001;
  endfunction

  task automatic packet(input logic ap, input logic rd, input logic [1:0] a,
                        input logic [DW-1:0] wd, input logic bad_hp,
                        input logic bad_stop, input logic bad_wp);
    logic [7:0] hb;
    logic en, v, any_en;
    logic [2:0] ack, eack;
    logic [DW-1:0] got;
    logic [DW-1:0] exp_rd;
    exp_req_t e;
    hb = {1'b1, bad_stop, (^{ap, rd, a}) ^ bad_hp, a[1], a[0], rd, ap, 1'b1};
    eack = model_ack(ap, a);
    if (!bad_hp && !bad_stop && eack == 3'b001 && rd) begin
      e = '{apndp: ap, rnw: 1'b1, addr: a, wdata: '0};
      exp_q.push_back(e);
    end
    any_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc(hb[i], en, v);
      any_en |= en;
    end
    if (bad_hp || bad_stop) begin
      for (int i = 0; i < 38; i++) begin
        cyc(1'b0, en, v);
        any_en |= en;
      end
      chk(!any_en, "R1 rejected header undriven", any_en, 0);
      return;
    end
    cyc(1'b0, en, v);
    any_en |= en;
    chk(!any_en, "R2 line free in header and turnaround", any_en, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, en, v);
      ack[i] = en ? v : 1'bx;
    end
    chk(ack === eack, "R2/R3 acknowledge", ack, eack);
    if (eack != 3'b001) begin
      cyc(1'b0, en, v);
      chk(!en, "R4 released in cycle 13", en, 0);
      return;
    end
    if (rd) begin
      exp_rd = ap ? post_m : rd_val;
      if (ap) post_m = rd_val;
      any_en = 1'b1;
      for (int i = 0; i < 32; i++) begin
        cyc(1'b0, en, v);
        any_en &= en;
        got[i] = v;
      end
      cyc(1'b0, en, v);
      any_en &= en;
      chk(any_en && got == exp_rd, ap ? "R7 posted read data" : "R6 read data", got, exp_rd);
      chk(v == ^exp_rd, "R5 read parity", v, ^exp_rd);
      cyc(1'b0, en, v);
      chk(!en, "R5 released in cycle 46", en, 0);
    end else begin
      cyc(1'b0, en, v);
      chk(!en, "R8 turnaround in cycle 13", en, 0);
      if (!bad_wp) begin
        e = '{apndp: ap, rnw: 1'b0, addr: a, wdata: wd};
        exp_q.push_back(e);
        if (!ap && a == 2'b00) sticky_m = 1'b0;
      end else begin
        sticky_m = 1'b1;
      end
      for (int i = 0; i < 32; i++) cyc(wd[i], en, v);
      cyc((^wd) ^ bad_wp, en, v);
    end
  endtask

  task automatic idle(input int n, input string tag);
    logic en, v, any_en;
    any_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, en, v);
      any_en |= en;
    end
    chk(!any_en, tag, any_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!swdio_oe && !req, "R12 reset state", {swdio_oe, req}, 0);
    rst_n = 1'b1;
    idle(25, "R11 long idle undriven");

    rd_val = 32'hC0DE_1234;
    packet(1'b0, 1'b1, 2'b01, '0, 0, 0, 0);           // R6 debug-port read
    rd_val = 32'hA5A5_0001;
    packet(1'b1, 1'b1, 2'b10, '0, 0, 0, 0);           // R7 first posted read gives 0
    rd_val = 32'h1111_2222;
    packet(1'b0, 1'b1, 2'b11, '0, 0, 0, 0);           // R7 DP read between
    rd_val = 32'h7E57_0002;
    packet(1'b1, 1'b1, 2'b00, '0, 0, 0, 0);           // R7 returns A5A50001
    packet(1'b0, 1'b0, 2'b10, 32'h8000_0001, 0, 0, 0); // R8 write
    packet(1'b1, 1'b0, 2'b01, 32'hFFFF_FFFE, 0, 0, 0); // R8 write
    idle(2, "R8 idle after write");

    ready = 1'b0;
    packet(1'b1, 1'b0, 2'b11, 32'h5, 0, 0, 0);        // R3 WAIT
    packet(1'b1, 1'b1, 2'b01, '0, 0, 0, 0);           // R4 back-to-back WAIT
    ready = 1'b1;
    err = 1'b1;
    packet(1'b1, 1'b1, 2'b00, '0, 0, 0, 0);           // R3 FAULT from error_i
    err = 1'b0;

    packet(1'b0, 1'b1, 2'b01, '0, 1, 0, 0);           // R1 bad parity
    packet(1'b0, 1'b1, 2'b01, '0, 0, 1, 0);           // R1 bad stop

    packet(1'b1, 1'b0, 2'b10, 32'h0BAD_0BAD, 0, 0, 1); // R9 bad write parity
    idle(3, "R9 no strobe after bad parity");
    packet(1'b1, 1'b1, 2'b10, '0, 0, 0, 0);           // R9 FAULT now
    rd_val = 32'h0000_ABCD;
    packet(1'b0, 1'b1, 2'b00, '0, 0, 0, 0);           // R3 DP addr 0 bypass
    packet(1'b0, 1'b0, 2'b00, 32'h1E, 0, 0, 0);       // R10 clear
    rd_val = 32'h0F0F_F0F0;
    packet(1'b1, 1'b1, 2'b11, '0, 0, 0, 0);           // R10 OK again
    idle(4, "R11 trailing idle");

    chk(exp_q.size() == 0, "R6/R8 all strobes seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule